// File: doc/BRIEF.md
# Sector-Granular Write-Back Cache for an Erase-Block Flash

This block lets a host treat a flash whose smallest erasable unit is a large erase block (eight sectors by default) as a flat array of small sectors. One erase block at a time is held in on-chip RAM, together with its block tag and three flags: a valid bit, a dirty bit and an erased-backing bit. Host requests name a starting sector, a sector count and an operation: read, write, erase or flush. Sector bytes travel over simple byte streams in both directions.

Toward the flash, the block drives a downstream engine with three commands: fill (stream a whole erase block into the cache), erase (clear one erase block) and program (stream the whole cached block back). Only one command is in flight at a time. The first change to a cached block erases its backing block. The whole block is then reprogrammed at the end of each write or erase request, or when a different block must be loaded while the cached one holds unsaved state. The block reports its geometry so that software can size the sector array.

Top module: `sector_cache`

## Requirements
- R1: The geometry outputs give a sector size of SECTOR_BYTES, an erase size of SECTOR_BYTES, and a sector count of NUM_EBLK*SLICES.
- R2: Sector number s maps to block tag s / SLICES and slice s % SLICES. A read (req_op=0) returns the SECTOR_BYTES bytes of that slice in ascending address order on rd_data/rd_valid.
- R3: A sector whose tag misses (cache invalid or a different tag) while the cache holds no unsaved state causes exactly one fill command (fl_cmd=0) at byte address tag*SECTOR_BYTES*SLICES, with no program command before it.
- R4: On a miss while the dirty or erased flag is set, a program command (fl_cmd=2) for the old block is issued and completed before the fill for the new block. The whole old block is streamed on fl_wdata/fl_wvalid.
- R5: A read of a sector in the cached block issues no downstream command.
- R6: A write (req_op=1) or erase (req_op=2) issues an erase command (fl_cmd=1) for the block only while the erased flag is clear. Further sectors of the same block in the same request issue no second erase.
- R7: An erase request sets every byte of the named slice to 0xFF.
- R8: A write request takes SECTOR_BYTES bytes per sector from wr_data, each on a cycle with wr_valid and wr_ready both high, and stores them into the slice in order.
- R9: After the last sector of a write or erase request, the cached block is programmed back and the dirty and erased flags clear. The next write to that block therefore issues a fresh erase, and the flash afterwards holds exactly the host's view.
- R10: A read never marks the cache dirty. A flush request (req_op=3) on a cache with no unsaved state issues no command.
- R11: busy is low after reset, is high from the cycle after a request is accepted until its whole sequence ends, and a second downstream command never starts while an erase or program awaits fl_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 0 read, 1 write, 2 erase, 3 flush |
| req_sector | input | SEC_W | First sector of the request |
| req_count | input | CNT_W | Number of sectors |
| busy | output | 1 | A request sequence is in progress |
| wr_data | input | 8 | Host write byte |
| wr_valid | input | 1 | Host write byte present |
| wr_ready | output | 1 | Cache accepts a write byte this cycle |
| rd_data | output | 8 | Read byte to host |
| rd_valid | output | 1 | Read byte present |
| fl_cmd_valid | output | 1 | One-cycle downstream command strobe |
| fl_cmd | output | 2 | 0 fill, 1 erase block, 2 program block |
| fl_addr | output | FA_W | Byte address of the erase block |
| fl_done | input | 1 | Erase or program finished |
| fl_rdata | input | 8 | Fill byte from flash |
| fl_rvalid | input | 1 | Fill byte present |
| fl_wdata | output | 8 | Program byte to flash |
| fl_wvalid | output | 1 | Program byte present |
| geo_block_bytes | output | 32 | Reported sector size |
| geo_erase_bytes | output | 32 | Reported erase size |
| geo_block_count | output | 32 | Reported sector count |

## Verification
The bench targets a multi-sector write that crosses an erase-block boundary. A design that skipped the flush on a dirty miss would lose the first block's data, and one that filled before programming would read back stale flash. It repeats a write to a block that was just written back, to catch an erased flag left set, which would skip the erase and program over live data. It also runs two sectors of one block in a single request, where a second erase would destroy the first sector. Read hits, a flush on a clean cache and a read across a block boundary confirm that no spurious fill, erase or program appears. A whole-flash comparison after every request catches slices placed at the wrong offset.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;

    typedef enum logic [1:0] {
        HOP_READ  = 2'd0,
        HOP_WRITE = 2'd1,
        HOP_ERASE = 2'd2,
        HOP_FLUSH = 2'd3
    } host_op_e;

    typedef enum logic [1:0] {
        FCMD_FILL  = 2'd0,
        FCMD_ERASE = 2'd1,
        FCMD_PROG  = 2'd2
    } flash_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOOK  = 3'd1,
        ST_PROG  = 3'd2,
        ST_PWAIT = 3'd3,
        ST_FILL  = 3'd4,
        ST_ERASE = 3'd5,
        ST_XFER  = 3'd6,
        ST_STEP  = 3'd7
    } cache_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/sector_cache_ram.sv
module sector_cache_ram #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sector_cache_lookup.sv
module sector_cache_lookup #(
    parameter int TAG_W = 8
) (
    input  logic             valid,
    input  logic             dirty,
    input  logic             erased,
    input  logic [TAG_W-1:0] held_tag,
    input  logic [TAG_W-1:0] want_tag,
    output logic             miss,
    output logic             flush_needed
);
    assign miss         = !valid || (held_tag != want_tag);
    assign flush_needed = valid && (dirty || erased);
endmodule

// File: rtl/sector_cache.sv
module sector_cache
    import sector_cache_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int SLICES       = 8,
    parameter int NUM_EBLK     = 256,
    parameter int CNT_W        = 8,
    localparam int BLK_BYTES   = SECTOR_BYTES * SLICES,
    localparam int SB_W        = $clog2(SECTOR_BYTES),
    localparam int SL_W        = $clog2(SLICES),
    localparam int BLK_AW      = SB_W + SL_W,
    localparam int TAG_W       = $clog2(NUM_EBLK),
    localparam int SEC_W       = TAG_W + SL_W,
    localparam int FA_W        = TAG_W + BLK_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [SEC_W-1:0] req_sector,
    input  logic [CNT_W-1:0] req_count,
    output logic             busy,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             fl_cmd_valid,
    output logic [1:0]       fl_cmd,
    output logic [FA_W-1:0]  fl_addr,
    input  logic             fl_done,
    input  logic [7:0]       fl_rdata,
    input  logic             fl_rvalid,
    output logic [7:0]       fl_wdata,
    output logic             fl_wvalid,
    output logic [31:0]      geo_block_bytes,
    output logic [31:0]      geo_erase_bytes,
    output logic [31:0]      geo_block_count
);
    localparam logic [BLK_AW-1:0] BLK_LAST   = BLK_AW'(BLK_BYTES - 1);
    localparam logic [SB_W-1:0]   SLICE_LAST = SB_W'(SECTOR_BYTES - 1);
    localparam logic [BLK_AW-1:0] BLK_ZERO   = '0;

    typedef struct packed {
        cache_state_e     st;
        host_op_e         op;
        logic [SEC_W-1:0] sector;
        logic [CNT_W-1:0] remain;
        logic [BLK_AW-1:0] cnt;
        logic             ret_fill;
        logic             valid;
        logic             dirty;
        logic             erased;
        logic [TAG_W-1:0] tag;
        logic             cmd_v;
        flash_cmd_e       cmd;
        logic [FA_W-1:0]  cmd_addr;
        logic             rd_v;
        logic             wr_v;
    } regs_t;

    regs_t q, d;

    logic              ram_we;
    logic [BLK_AW-1:0] ram_waddr, ram_raddr, slice_addr;
    logic [7:0]        ram_wdata, ram_rdata;
    logic [TAG_W-1:0]  cur_tag;
    logic              miss, flush_needed, step;
    logic              flag_erased;

    assign cur_tag     = q.sector[SEC_W-1:SL_W];
    assign slice_addr  = {q.sector[SL_W-1:0], q.cnt[SB_W-1:0]};
    assign flag_erased = q.erased;

    sector_cache_lookup #(.TAG_W(TAG_W)) u_lookup (
        .valid       (q.valid),
        .dirty       (q.dirty),
        .erased      (q.erased),
        .held_tag    (q.tag),
        .want_tag    (cur_tag),
        .miss        (miss),
        .flush_needed(flush_needed)
    );

    sector_cache_ram #(.DEPTH(BLK_BYTES)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(ram_wdata),
        .raddr(ram_raddr),
        .rdata(ram_rdata)
    );

    // Start writing the held block back; ret selects a fill afterwards.
    function automatic regs_t go_prog(regs_t r, logic ret);
        r.st       = ST_PROG;
        r.cmd_v    = 1'b1;
        r.cmd      = FCMD_PROG;
        r.cmd_addr = {r.tag, BLK_ZERO};
        r.cnt      = '0;
        r.ret_fill = ret;
        return r;
    endfunction

    // Start loading the block that holds the current sector.
    function automatic regs_t go_fill(regs_t r);
        r.st       = ST_FILL;
        r.cmd_v    = 1'b1;
        r.cmd      = FCMD_FILL;
        r.cmd_addr = {r.sector[SEC_W-1:SL_W], BLK_ZERO};
        r.cnt      = '0;
        r.valid    = 1'b0;
        return r;
    endfunction

    always_comb begin
        d         = q;
        d.cmd_v   = 1'b0;
        d.rd_v    = 1'b0;
        d.wr_v    = 1'b0;
        ram_we    = 1'b0;
        ram_waddr = q.cnt;
        ram_wdata = fl_rdata;
        ram_raddr = q.cnt;
        wr_ready  = 1'b0;
        step      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op     = host_op_e'(req_op);
                    d.sector = req_sector;
                    d.remain = req_count;
                    d.cnt    = '0;
                    if (host_op_e'(req_op) == HOP_FLUSH) begin
                        if (flush_needed) d = go_prog(d, 1'b0);
                    end else if (req_count != '0) begin
                        d.st = ST_LOOK;
                    end
                end
            end
            ST_LOOK: begin
                if (miss) begin
                    d = flush_needed ? go_prog(d, 1'b1) : go_fill(d);
                end else if (q.op != HOP_READ && !q.erased) begin
                    d.st       = ST_ERASE;
                    d.cmd_v    = 1'b1;
                    d.cmd      = FCMD_ERASE;
                    d.cmd_addr = {cur_tag, BLK_ZERO};
                end else begin
                    d.st  = ST_XFER;
                    d.cnt = '0;
                end
            end
            ST_PROG: begin
                d.wr_v = 1'b1;
                d.cnt  = q.cnt + BLK_AW'(1);
                if (q.cnt == BLK_LAST) d.st = ST_PWAIT;
            end
            ST_PWAIT: begin
                if (fl_done) begin
                    d.dirty  = 1'b0;
                    d.erased = 1'b0;
                    if (q.ret_fill) d = go_fill(d);
                    else            d.st = ST_IDLE;
                end
            end
            ST_FILL: begin
                if (fl_rvalid) begin
                    ram_we = 1'b1;
                    d.cnt  = q.cnt + BLK_AW'(1);
                    if (q.cnt == BLK_LAST) begin
                        d.tag    = cur_tag;
                        d.valid  = 1'b1;
                        d.dirty  = 1'b0;
                        d.erased = 1'b0;
                        d.st     = ST_LOOK;
                    end
                end
            end
            ST_ERASE: begin
                if (fl_done) begin
                    d.erased = 1'b1;
                    d.st     = ST_XFER;
                    d.cnt    = '0;
                end
            end
            ST_XFER: begin
                ram_raddr = slice_addr;
                ram_waddr = slice_addr;
                case (q.op)
                    HOP_READ: begin
                        d.rd_v = 1'b1;
                        step   = 1'b1;
                    end
                    HOP_WRITE: begin
                        wr_ready  = 1'b1;
                        ram_wdata = wr_data;
                        ram_we    = wr_valid;
                        step      = wr_valid;
                    end
                    default: begin
                        ram_wdata = ERASED_BYTE;
                        ram_we    = 1'b1;
                        step      = 1'b1;
                    end
                endcase
                if (step) begin
                    d.cnt = q.cnt + BLK_AW'(1);
                    if (q.cnt[SB_W-1:0] == SLICE_LAST) begin
                        d.st = ST_STEP;
                        if (q.op != HOP_READ) d.dirty = 1'b1;
                    end
                end
            end
            ST_STEP: begin
                d.remain = q.remain - CNT_W'(1);
                d.sector = q.sector + SEC_W'(1);
                if (q.remain > CNT_W'(1))      d.st = ST_LOOK;
                else if (q.op != HOP_READ)     d = go_prog(d, 1'b0);
                else                           d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy            = (q.st != ST_IDLE) || q.rd_v;
    assign rd_valid        = q.rd_v;
    assign rd_data         = ram_rdata;
    assign fl_wvalid       = q.wr_v;
    assign fl_wdata        = ram_rdata;
    assign fl_cmd_valid    = q.cmd_v;
    assign fl_cmd          = q.cmd;
    assign fl_addr         = q.cmd_addr;
    assign geo_block_bytes = 32'(SECTOR_BYTES);
    assign geo_erase_bytes = 32'(SECTOR_BYTES);
    assign geo_block_count = 32'(NUM_EBLK * SLICES);

endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       fl_cmd_valid,
    input logic [1:0] fl_cmd,
    input logic       fl_done,
    input logic       fl_wvalid,
    input logic       flag_erased
);
    logic pend;

    always_ff @(posedge clk) begin
        if (!rst_n)                              pend <= 1'b0;
        else if (fl_done)                        pend <= 1'b0;
        else if (fl_cmd_valid && fl_cmd != 2'd0) pend <= 1'b1;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !fl_cmd_valid);                                        // R11
    AST_CMD_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cmd_valid |-> busy);                                         // R11
    AST_PROG_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_wvalid) |-> $past(fl_cmd_valid && fl_cmd == 2'd2));    // R9
    AST_WRITE_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> flag_erased);                                      // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !fl_wvalid);                                          // R9
    AST_READ_NOT_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !fl_wvalid);                                       // R5
endmodule

bind sector_cache sector_cache_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .wr_ready    (wr_ready),
    .rd_valid    (rd_valid),
    .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd      (fl_cmd),
    .fl_done     (fl_done),
    .fl_wvalid   (fl_wvalid),
    .flag_erased (flag_erased)
);

// File: tb/sim_sector_cache.sv
module sim_sector_cache;
    localparam int SB    = 64;
    localparam int SL    = 8;
    localparam int NE    = 4;
    localparam int CNT_W = 8;
    localparam int BLK   = SB * SL;
    localparam int NB    = BLK * NE;
    localparam int SEC_W = 5;
    localparam int FA_W  = 11;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid;
    logic [1:0] req_op;
    logic [SEC_W-1:0] req_sector;
    logic [CNT_W-1:0] req_count;
    logic busy, wr_ready, rd_valid, fl_cmd_valid, fl_wvalid;
    logic [7:0] wr_data, rd_data, fl_rdata, fl_wdata;
    logic wr_valid, fl_done, fl_rvalid;
    logic [1:0] fl_cmd;
    logic [FA_W-1:0] fl_addr;
    logic [31:0] geo_block_bytes, geo_erase_bytes, geo_block_count;

    always #2.5 clk = ~clk;

    sector_cache #(.SECTOR_BYTES(SB), .SLICES(SL), .NUM_EBLK(NE), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sector(req_sector), .req_count(req_count), .busy(busy),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .fl_cmd_valid(fl_cmd_valid),
        .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_done(fl_done),
        .fl_rdata(fl_rdata), .fl_rvalid(fl_rvalid), .fl_wdata(fl_wdata),
        .fl_wvalid(fl_wvalid), .geo_block_bytes(geo_block_bytes),
        .geo_erase_bytes(geo_erase_bytes), .geo_block_count(geo_block_count)
    );

    int checks = 0;
    int bad = 0;
    bit finished = 0;
    string cur_tag = "R1";

    logic [7:0] fm  [NB];   // flash model contents
    logic [7:0] lim [NB];   // host's logical view
    int   exp_cmd[$];
    logic [7:0] exp_rd[$];
    logic [7:0] wq[$];

    // expected cache state, from the requirements
    bit m_valid = 0, m_dirty = 0, m_erased = 0;
    int m_tag = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // flash engine model and command scoreboard
    initial begin : flash_model
        fl_done = 0; fl_rvalid = 0; fl_rdata = 0;
        @(negedge clk);
        forever begin
            if (rst_n && fl_cmd_valid) begin : handle
                automatic int code = int'(fl_cmd) * 65536 + int'(fl_addr);
                automatic int base = int'(fl_addr);
                automatic int n = 0;
                checks++;
                if (exp_cmd.size() == 0) begin
                    bad++;
                    $display("FAIL %s unexpected flash command act=%0h exp=none", cur_tag, code);
                end else begin
                    automatic int e = exp_cmd.pop_front();
                    if (e != code) begin
                        bad++;
                        $display("FAIL %s flash command act=%0h exp=%0h", cur_tag, code, e);
                    end
                end
                case (fl_cmd)
                    2'd0: begin
                        for (int i = 0; i < BLK; i++) begin
                            fl_rvalid = 1; fl_rdata = fm[base + i];
                            @(negedge clk);
                        end
                        fl_rvalid = 0;
                    end
                    2'd1: begin
                        repeat (3) @(negedge clk);
                        for (int i = 0; i < BLK; i++) fm[base + i] = 8'hFF;
                        fl_done = 1; @(negedge clk); fl_done = 0;
                    end
                    default: begin
                        while (n < BLK) begin
                            @(negedge clk);
                            if (fl_wvalid) begin fm[base + n] = fl_wdata; n++; end
                        end
                        @(negedge clk); fl_done = 1; @(negedge clk); fl_done = 0;
                    end
                endcase
            end else begin
                @(negedge clk);
            end
        end
    end

    // read-data monitor
    initial begin : read_mon
        forever begin
            @(negedge clk);
            if (rst_n && rd_valid) begin
                checks++;
                if (exp_rd.size() == 0) begin
                    bad++;
                    $display("FAIL %s unexpected read byte act=%0h exp=none", cur_tag, rd_data);
                end else begin
                    automatic logic [7:0] e = exp_rd.pop_front();
                    if (rd_data !== e) begin
                        bad++;
                        $display("FAIL %s read byte act=%0h exp=%0h", cur_tag, rd_data, e);
                    end
                end
            end
        end
    end

    // host write-byte feeder (R8 handshake)
    initial begin : feeder
        automatic bit rdy = 0;
        wr_valid = 0; wr_data = 0;
        forever begin
            @(negedge clk);
            if (wr_valid && rdy) void'(wq.pop_front());
            rdy = wr_ready;
            if (wq.size() > 0) begin wr_valid = 1; wr_data = wq[0]; end
            else wr_valid = 0;
        end
    end

    // driver: predicts commands and data, then issues the request
    task automatic do_req(input int op, input int sec, input int cnt, input int seed,
                          input string tag);
        int mism;
        cur_tag = tag;
        for (int k = 0; k < cnt; k++) begin
            automatic int s = sec + k;
            automatic int t = s / SL;
            automatic int base = t * BLK + (s % SL) * SB;
            if (!m_valid || m_tag != t) begin
                if (m_valid && (m_dirty || m_erased)) exp_cmd.push_back(2 * 65536 + m_tag * BLK);
                exp_cmd.push_back(t * BLK);
                m_valid = 1; m_tag = t; m_dirty = 0; m_erased = 0;
            end
            if (op != 0 && !m_erased) begin
                exp_cmd.push_back(65536 + t * BLK);
                m_erased = 1;
            end
            for (int i = 0; i < SB; i++) begin
                case (op)
                    0: exp_rd.push_back(lim[base + i]);
                    1: begin
                        automatic logic [7:0] b = 8'((seed + 7 * i + 3 * k) & 255);
                        wq.push_back(b);
                        lim[base + i] = b;
                    end
                    default: lim[base + i] = 8'hFF;
                endcase
            end
            if (op != 0) m_dirty = 1;
        end
        if (op != 0 && (m_dirty || m_erased)) begin
            exp_cmd.push_back(2 * 65536 + m_tag * BLK);
            m_dirty = 0; m_erased = 0;
        end
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_sector = SEC_W'(sec); req_count = CNT_W'(cnt);
        @(negedge clk);
        req_valid = 0;
        if (op != 3) chk({tag, " R11 busy after accept"}, int'(busy), 1);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk({tag, " pending commands"}, exp_cmd.size(), 0);
        chk({tag, " pending reads"}, exp_rd.size(), 0);
        chk({tag, " R8 unconsumed write bytes"}, wq.size(), 0);
        mism = 0;
        for (int i = 0; i < NB; i++) if (fm[i] !== lim[i]) mism++;
        chk({tag, " R9 flash image mismatches"}, mism, 0);
        exp_cmd.delete(); exp_rd.delete(); wq.delete();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL R11 watchdog: busy act=%0d exp=0", busy);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin : main
        for (int i = 0; i < NB; i++) begin
            fm[i]  = 8'((i * 13 + 5) & 255);
            lim[i] = fm[i];
        end
        rst_n = 0; req_valid = 0; req_op = 0; req_sector = 0; req_count = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 no command after reset", int'(fl_cmd_valid), 0);
        chk("R2 no read data after reset", int'(rd_valid), 0);
        chk("R1 sector size", int'(geo_block_bytes), SB);
        chk("R1 erase size", int'(geo_erase_bytes), SB);
        chk("R1 sector count", int'(geo_block_count), NE * SL);

        do_req(0, 3, 1, 0, "R3 R2 cold read miss");
        do_req(0, 5, 1, 0, "R5 read hit");
        do_req(3, 0, 0, 0, "R10 flush clean");
        do_req(1, 2, 2, 17, "R6 two-sector write one erase");
        do_req(0, 2, 2, 0, "R8 read back written");
        do_req(3, 0, 0, 0, "R10 flush after read");
        do_req(2, 9, 1, 0, "R7 sector erase");
        do_req(0, 9, 1, 0, "R7 read erased slice");
        do_req(1, 6, 4, 91, "R4 write across blocks");
        do_req(1, 8, 1, 44, "R9 rewrite re-erases");
        do_req(0, 7, 4, 0, "R3 read across blocks");
        do_req(2, 31, 1, 0, "R7 erase last sector");
        do_req(1, 24, 3, 200, "R6 write last block");
        do_req(0, 24, 8, 0, "R2 read whole last block");

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule